// File: doc/BRIEF.md
# Banked CPU Register File

This block holds the architectural state of a small 8-bit processor core: an accumulator, an index register, a stack pointer and a flags byte. The instruction path writes each of them through its own enable and data pair. Push and pop strobes move the stack pointer and produce the RAM address that the stack access must use. A push uses the current pointer and then advances it. A pop steps the pointer back first and uses the new value. The pointer wraps around the 256-byte stack page in both directions, and no overflow is reported.

The block also decodes a 256-byte configuration register space that exists in two banks. One location, which is the same in both banks, is the flags byte itself. Every other location is passed to one of two external bank ports. A flag bit picks which bank port gets the access. Software changes banks by writing that bit through the configuration space. The new bank applies from the next access onward.

Top module: `cpu_regbank`

## Requirements
- R1: After reset the accumulator, index and stack pointer read 00h, the flags read 02h (zero flag, bit 1, set), and the selected bank is 0.
- R2: When its write enable is high at a rising edge, the accumulator, index, stack pointer or flags register takes its write data, and the new value is visible after that edge.
- R3: While push alone is asserted, stack_addr equals the current stack pointer, and the pointer is one higher after the edge.
- R4: While pop alone is asserted, stack_addr equals the stack pointer minus one, and the pointer takes that value after the edge.
- R5: A push at FFh leaves the pointer at 00h, and a pop at 00h leaves it at FFh. Neither wrap changes the flags.
- R6: Push and pop together leave the pointer unchanged, with stack_addr equal to the pointer. A direct stack-pointer write beats any stack strobe.
- R7: A configuration read of address F7h returns the flags byte whichever bank is selected, and asserts neither bank enable.
- R8: A configuration write to F7h stores all eight bits into the flags, including the bank bit (bit 4, 1 = bank 1). It beats a same-cycle direct flags write.
- R9: A configuration read or write of any other address asserts exactly one bank enable. bank1_en is used when flags bit 4 is 1, and bank0_en when it is 0. bank_wr follows the write strobe, and the address and write data pass through unchanged.
- R10: On a read of any address other than F7h, cfg_rdata carries the selected bank's read data. When no read strobe is present, cfg_rdata is 00h.
- R11: bank_sel always reflects flags bit 4, so a bank change written at one access governs the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_we | input | 1 | Accumulator write enable |
| a_wdata | input | 8 | Accumulator write data |
| x_we | input | 1 | Index write enable |
| x_wdata | input | 8 | Index write data |
| sp_we | input | 1 | Stack pointer direct write enable |
| sp_wdata | input | 8 | Stack pointer write data |
| f_we | input | 1 | Flags direct write enable |
| f_wdata | input | 8 | Flags write data |
| push | input | 1 | Stack push strobe |
| pop | input | 1 | Stack pop strobe |
| cfg_addr | input | 8 | Configuration space address |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| bank0_rdata | input | 8 | Read data from bank 0 port |
| bank1_rdata | input | 8 | Read data from bank 1 port |
| a_q | output | 8 | Accumulator value |
| x_q | output | 8 | Index value |
| sp_q | output | 8 | Stack pointer value |
| f_q | output | 8 | Flags value |
| stack_addr | output | 8 | RAM address for the current stack access |
| bank_sel | output | 1 | Selected configuration bank |
| cfg_rdata | output | 8 | Configuration read data |
| bank0_en | output | 1 | Bank 0 access enable |
| bank1_en | output | 1 | Bank 1 access enable |
| bank_wr | output | 1 | Write qualifier for the bank ports |
| bank_addr | output | 8 | Address forwarded to the bank ports |
| bank_wdata | output | 8 | Write data forwarded to the bank ports |

## Verification
On every cycle, the assertions check the stack pointer steps for single push and pop, its hold when both strobes are present, and that at most one bank enable is active. They also check that the bank enable agrees with the stored bank bit, that an F7h access never reaches a bank port, and that a write to F7h lands in the flags. Only the bench's scenarios can show the reset values, wrapping at both ends of the stack page, and the priority of direct writes over stack strobes and configuration writes. The same holds for the read-data multiplexing and for a bank switch taking effect on the very next access. These are compared against a behavioural model cycle by cycle.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   typedef enum logic [1:0] {
      STK_IDLE = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2,
      STK_BOTH = 2'd3
   } stk_op_e;

   function automatic stk_op_e stk_op_of(input logic push, input logic pop);
      return stk_op_e'({pop, push});
   endfunction

   localparam int unsigned BANK_CNT = 2;

endpackage

// File: rtl/rb_data_reg.sv
module rb_data_reg #(
   parameter int unsigned W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d;
   end

endmodule

// File: rtl/rb_stack_ptr.sv
module rb_stack_ptr
   import regbank_pkg::*;
#(
   parameter int unsigned  W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] sp,
   output logic [W-1:0] addr
);

   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] sp_nxt;
   logic [W-1:0] sp_dec;
   stk_op_e      op;

   assign sp_dec = sp - ONE;

   always_comb begin
      op     = stk_op_of(push, pop);
      sp_nxt = sp;
      addr   = sp;
      unique case (op)
         STK_PUSH: sp_nxt = sp + ONE;
         STK_POP: begin
            sp_nxt = sp_dec;
            addr   = sp_dec;
         end
         default: sp_nxt = sp;
      endcase
      if (ld) sp_nxt = ld_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sp <= RST;
      else        sp <= sp_nxt;
   end

endmodule

// File: rtl/rb_flag_reg.sv
module rb_flag_reg #(
   parameter int unsigned  W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_ld,
   input  logic [W-1:0] cfg_val,
   input  logic         core_ld,
   input  logic [W-1:0] core_val,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= RST;
      else if (cfg_ld)  q <= cfg_val;
      else if (core_ld) q <= core_val;
   end

endmodule

// File: rtl/rb_cfg_decode.sv
module rb_cfg_decode
   import regbank_pkg::*;
#(
   parameter int unsigned   AW        = 8,
   parameter int unsigned   DW        = 8,
   parameter logic [AW-1:0] FLAG_ADDR = '1
) (
   input  logic                clk,
   input  logic [AW-1:0]       cfg_addr,
   input  logic                cfg_rd,
   input  logic                cfg_wr,
   input  logic                bank,
   input  logic [DW-1:0]       f_val,
   input  logic [DW-1:0]       b0_rdata,
   input  logic [DW-1:0]       b1_rdata,
   output logic                flag_ld,
   output logic [BANK_CNT-1:0] bank_en,
   output logic                bank_wr,
   output logic [DW-1:0]       rdata
);

   logic flag_hit;
   logic any_acc;
   logic ext_acc;
   logic unused_clk;

   assign unused_clk = clk;
   assign any_acc    = cfg_rd | cfg_wr;
   assign flag_hit   = (cfg_addr == FLAG_ADDR);
   assign ext_acc    = any_acc & ~flag_hit;
   assign flag_ld    = cfg_wr & flag_hit;
   assign bank_wr    = cfg_wr & ~flag_hit;

   for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank_en
      localparam logic SEL = (b == 1);
      assign bank_en[b] = ext_acc & (bank == SEL);
   end

   always_comb begin
      rdata = '0;
      if (cfg_rd) begin
         if (flag_hit)  rdata = f_val;
         else if (bank) rdata = b1_rdata;
         else           rdata = b0_rdata;
      end
   end

endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
   import regbank_pkg::*;
#(
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       CFG_AW    = 8,
   parameter logic [CFG_AW-1:0] FLAG_ADDR = 8'hF7,
   parameter int unsigned       ZERO_BIT  = 1,
   parameter int unsigned       BANK_BIT  = 4,
   parameter logic [DATA_W-1:0] FLAG_RST  = 8'h02,
   parameter logic [DATA_W-1:0] SP_RST    = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_we,
   input  logic [DATA_W-1:0] a_wdata,
   input  logic              x_we,
   input  logic [DATA_W-1:0] x_wdata,
   input  logic              sp_we,
   input  logic [DATA_W-1:0] sp_wdata,
   input  logic              f_we,
   input  logic [DATA_W-1:0] f_wdata,
   input  logic              push,
   input  logic              pop,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic              cfg_rd,
   input  logic              cfg_wr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic [DATA_W-1:0] bank0_rdata,
   input  logic [DATA_W-1:0] bank1_rdata,
   output logic [DATA_W-1:0] a_q,
   output logic [DATA_W-1:0] x_q,
   output logic [DATA_W-1:0] sp_q,
   output logic [DATA_W-1:0] f_q,
   output logic [DATA_W-1:0] stack_addr,
   output logic              bank_sel,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              bank0_en,
   output logic              bank1_en,
   output logic              bank_wr,
   output logic [CFG_AW-1:0] bank_addr,
   output logic [DATA_W-1:0] bank_wdata
);

   localparam int unsigned GPR_CNT = 2;

   if (DATA_W < 2) begin : g_bad_width
      $error("cpu_regbank: DATA_W must be at least 2");
   end
   if (BANK_BIT >= DATA_W || ZERO_BIT >= DATA_W) begin : g_bad_bit
      $error("cpu_regbank: flag bit positions exceed DATA_W");
   end
   if (BANK_BIT == ZERO_BIT) begin : g_bit_clash
      $error("cpu_regbank: bank bit and zero bit must differ");
   end
   if (FLAG_RST[BANK_BIT] != 1'b0) begin : g_bad_rst_bank
      $error("cpu_regbank: reset must select bank 0");
   end
   if (FLAG_RST[ZERO_BIT] != 1'b1) begin : g_bad_rst_zero
      $error("cpu_regbank: reset must set the zero flag");
   end

   logic              gpr_we [GPR_CNT];
   logic [DATA_W-1:0] gpr_d  [GPR_CNT];
   logic [DATA_W-1:0] gpr_q  [GPR_CNT];

   assign gpr_we[0] = a_we;
   assign gpr_d[0]  = a_wdata;
   assign gpr_we[1] = x_we;
   assign gpr_d[1]  = x_wdata;

   for (genvar g = 0; g < GPR_CNT; g++) begin : g_gpr
      rb_data_reg #(
         .W   (DATA_W),
         .RST ('0)
      ) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (gpr_we[g]),
         .d     (gpr_d[g]),
         .q     (gpr_q[g])
      );
   end

   assign a_q = gpr_q[0];
   assign x_q = gpr_q[1];

   rb_stack_ptr #(
      .W   (DATA_W),
      .RST (SP_RST)
   ) u_sp (
      .clk    (clk),
      .rst_n  (rst_n),
      .push   (push),
      .pop    (pop),
      .ld     (sp_we),
      .ld_val (sp_wdata),
      .sp     (sp_q),
      .addr   (stack_addr)
   );

   logic                flag_ld;
   logic [BANK_CNT-1:0] bank_en;

   rb_flag_reg #(
      .W   (DATA_W),
      .RST (FLAG_RST)
   ) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_ld   (flag_ld),
      .cfg_val  (cfg_wdata),
      .core_ld  (f_we),
      .core_val (f_wdata),
      .q        (f_q)
   );

   assign bank_sel = f_q[BANK_BIT];

   rb_cfg_decode #(
      .AW        (CFG_AW),
      .DW        (DATA_W),
      .FLAG_ADDR (FLAG_ADDR)
   ) u_dec (
      .clk      (clk),
      .cfg_addr (cfg_addr),
      .cfg_rd   (cfg_rd),
      .cfg_wr   (cfg_wr),
      .bank     (bank_sel),
      .f_val    (f_q),
      .b0_rdata (bank0_rdata),
      .b1_rdata (bank1_rdata),
      .flag_ld  (flag_ld),
      .bank_en  (bank_en),
      .bank_wr  (bank_wr),
      .rdata    (cfg_rdata)
   );

   assign bank0_en   = bank_en[0];
   assign bank1_en   = bank_en[1];
   assign bank_addr  = cfg_addr;
   assign bank_wdata = cfg_wdata;

endmodule

// File: rtl/cpu_regbank_chk.sv
module cpu_regbank_chk #(
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       CFG_AW    = 8,
   parameter logic [CFG_AW-1:0] FLAG_ADDR = 8'hF7,
   parameter int unsigned       BANK_BIT  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push,
   input logic              pop,
   input logic              sp_we,
   input logic              cfg_rd,
   input logic              cfg_wr,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic [DATA_W-1:0] sp_q,
   input logic [DATA_W-1:0] f_q,
   input logic              bank0_en,
   input logic              bank1_en,
   input logic              bank_wr
);

   localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

   // R3
   push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !sp_we) |=> (sp_q == $past(sp_q) + ONE));

   // R4
   pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !sp_we) |=> (sp_q == $past(sp_q) - ONE));

   // R6
   sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !sp_we) |=> $stable(sp_q));

   // R9
   bank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bank0_en, bank1_en}));

   // R9
   bank1_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank1_en |-> f_q[BANK_BIT]);

   // R9
   bank_wr_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bank_wr |-> (cfg_wr && (bank0_en || bank1_en)));

   // R7
   flag_no_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_rd || cfg_wr) && cfg_addr == FLAG_ADDR) |-> !(bank0_en || bank1_en));

   // R8
   flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_addr == FLAG_ADDR) |=> (f_q == $past(cfg_wdata)));

endmodule

bind cpu_regbank cpu_regbank_chk #(
   .DATA_W    (DATA_W),
   .CFG_AW    (CFG_AW),
   .FLAG_ADDR (FLAG_ADDR),
   .BANK_BIT  (BANK_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .push      (push),
   .pop       (pop),
   .sp_we     (sp_we),
   .cfg_rd    (cfg_rd),
   .cfg_wr    (cfg_wr),
   .cfg_addr  (cfg_addr),
   .cfg_wdata (cfg_wdata),
   .sp_q      (sp_q),
   .f_q       (f_q),
   .bank0_en  (bank0_en),
   .bank1_en  (bank1_en),
   .bank_wr   (bank_wr)
);

// File: tb/tb_cpu_regbank.sv
module tb_cpu_regbank;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       a_we = 0, x_we = 0, sp_we = 0, f_we = 0, push = 0, pop = 0;
   logic [7:0] a_wdata = 0, x_wdata = 0, sp_wdata = 0, f_wdata = 0;
   logic [7:0] cfg_addr = 0, cfg_wdata = 0, bank0_rdata = 0, bank1_rdata = 0;
   logic       cfg_rd = 0, cfg_wr = 0;
   logic [7:0] a_q, x_q, sp_q, f_q, stack_addr, cfg_rdata, bank_addr, bank_wdata;
   logic       bank_sel, bank0_en, bank1_en, bank_wr;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [7:0] m_a, m_x, m_sp, m_f;

   always #4 clk = ~clk;

   cpu_regbank dut (
      .clk(clk), .rst_n(rst_n),
      .a_we(a_we), .a_wdata(a_wdata), .x_we(x_we), .x_wdata(x_wdata),
      .sp_we(sp_we), .sp_wdata(sp_wdata), .f_we(f_we), .f_wdata(f_wdata),
      .push(push), .pop(pop),
      .cfg_addr(cfg_addr), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .bank0_rdata(bank0_rdata), .bank1_rdata(bank1_rdata),
      .a_q(a_q), .x_q(x_q), .sp_q(sp_q), .f_q(f_q), .stack_addr(stack_addr),
      .bank_sel(bank_sel), .cfg_rdata(cfg_rdata),
      .bank0_en(bank0_en), .bank1_en(bank1_en), .bank_wr(bank_wr),
      .bank_addr(bank_addr), .bank_wdata(bank_wdata)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      a_we = 0; x_we = 0; sp_we = 0; f_we = 0; push = 0; pop = 0;
      cfg_rd = 0; cfg_wr = 0;
   endtask

   // compare every output against the behavioural model
   task automatic compare_all();
      bit acc, fhit, ext;
      logic [7:0] e_saddr, e_rd;
      acc  = cfg_rd | cfg_wr;
      fhit = (cfg_addr == 8'hF7);
      ext  = acc && !fhit;
      if (push && !pop)      e_saddr = m_sp;
      else if (pop && !push) e_saddr = m_sp - 8'd1;
      else                   e_saddr = m_sp;
      if (!cfg_rd)    e_rd = 8'h00;
      else if (fhit)  e_rd = m_f;
      else if (m_f[4]) e_rd = bank1_rdata;
      else            e_rd = bank0_rdata;
      chk("R2 a_q", a_q, m_a);
      chk("R2 x_q", x_q, m_x);
      chk("R3 sp_q", sp_q, m_sp);
      chk("R8 f_q", f_q, m_f);
      chk("R4 stack_addr", stack_addr, e_saddr);
      chk("R11 bank_sel", bank_sel, m_f[4]);
      chk("R9 bank0_en", bank0_en, ext && !m_f[4]);
      chk("R9 bank1_en", bank1_en, ext && m_f[4]);
      chk("R9 bank_wr", bank_wr, cfg_wr && !fhit);
      chk("R9 bank_addr", bank_addr, cfg_addr);
      chk("R9 bank_wdata", bank_wdata, cfg_wdata);
      chk(fhit ? "R7 cfg_rdata" : "R10 cfg_rdata", cfg_rdata, e_rd);
   endtask

   task automatic model_step();
      if (a_we) m_a = a_wdata;
      if (x_we) m_x = x_wdata;
      if (cfg_wr && cfg_addr == 8'hF7) m_f = cfg_wdata;
      else if (f_we)                   m_f = f_wdata;
      if (sp_we)             m_sp = sp_wdata;
      else if (push && !pop) m_sp = m_sp + 8'd1;
      else if (pop && !push) m_sp = m_sp - 8'd1;
   endtask

   task automatic cyc();
      @(negedge clk);
      compare_all();
      model_step();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      m_a = 0; m_x = 0; m_sp = 0; m_f = 8'h02;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 a_q", a_q, 0);
      chk("R1 x_q", x_q, 0);
      chk("R1 sp_q", sp_q, 0);
      chk("R1 f_q", f_q, 8'h02);
      chk("R1 bank_sel", bank_sel, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R2 direct writes
      a_we = 1; a_wdata = 8'h5A; x_we = 1; x_wdata = 8'hA5;
      f_we = 1; f_wdata = 8'h83;
      cyc(); idle();
      chk("R2 a write", a_q, 8'h5A);
      chk("R2 x write", x_q, 8'hA5);
      chk("R2 f write", f_q, 8'h83);

      // R5 wrap upward
      sp_we = 1; sp_wdata = 8'hFE; cyc(); idle();
      push = 1; cyc();
      chk("R5 sp at FF", sp_q, 8'hFF);
      @(negedge clk);
      chk("R5 push addr at FF", stack_addr, 8'hFF);
      @(posedge clk); #1;
      model_step();
      idle();
      chk("R5 push wraps to 00", sp_q, 8'h00);
      chk("R5 flags untouched", f_q, 8'h83);
      // R5 wrap downward
      pop = 1;
      @(negedge clk);
      chk("R5 pop addr at 00", stack_addr, 8'hFF);
      compare_all(); model_step();
      @(posedge clk); #1; idle();
      chk("R5 pop wraps to FF", sp_q, 8'hFF);
      chk("R5 flags untouched after pop", f_q, 8'h83);

      // R6 both strobes, and direct load wins
      push = 1; pop = 1; cyc();
      chk("R6 both strobes hold", sp_q, 8'hFF);
      sp_we = 1; sp_wdata = 8'h40; push = 1; pop = 0; cyc(); idle();
      chk("R6 load beats push", sp_q, 8'h40);

      // R7 read F7 in bank 0
      cfg_rd = 1; cfg_addr = 8'hF7; bank0_rdata = 8'h11; bank1_rdata = 8'h22;
      @(negedge clk);
      chk("R7 flag read bank0", cfg_rdata, 8'h83);
      chk("R7 no enable", {bank0_en, bank1_en}, 0);
      @(posedge clk); #1; idle();

      // R8 write F7 with bank bit, beats f_we
      cfg_wr = 1; cfg_addr = 8'hF7; cfg_wdata = 8'hB5; f_we = 1; f_wdata = 8'h00;
      cyc(); idle();
      chk("R8 flag via cfg", f_q, 8'hB5);
      chk("R11 bank now 1", bank_sel, 1);
      // R9 next access in bank 1
      cfg_rd = 1; cfg_addr = 8'h20; bank0_rdata = 8'h33; bank1_rdata = 8'h44;
      @(negedge clk);
      chk("R9 bank1 enable", bank1_en, 1);
      chk("R9 bank0 quiet", bank0_en, 0);
      chk("R10 bank1 data", cfg_rdata, 8'h44);
      @(posedge clk); #1; idle();
      cfg_rd = 1; cfg_addr = 8'hF7;
      @(negedge clk);
      chk("R7 flag read bank1", cfg_rdata, 8'hB5);
      @(posedge clk); #1; idle();
      // back to bank 0
      cfg_wr = 1; cfg_addr = 8'hF7; cfg_wdata = 8'h02; cyc(); idle();
      cfg_wr = 1; cfg_addr = 8'h10; cfg_wdata = 8'h9C;
      @(negedge clk);
      chk("R9 bank0 write enable", bank0_en, 1);
      chk("R9 bank write qualifier", bank_wr, 1);
      @(posedge clk); #1; idle();
      @(negedge clk);
      chk("R10 idle rdata zero", cfg_rdata, 0);
      @(posedge clk); #1;

      // random traffic compared each cycle
      for (int i = 0; i < 4000; i++) begin
         a_we  = ($urandom_range(0, 3) == 0); a_wdata  = 8'($urandom);
         x_we  = ($urandom_range(0, 3) == 0); x_wdata  = 8'($urandom);
         sp_we = ($urandom_range(0, 15) == 0); sp_wdata = 8'($urandom);
         f_we  = ($urandom_range(0, 7) == 0); f_wdata  = 8'($urandom);
         push  = ($urandom_range(0, 2) == 0);
         pop   = ($urandom_range(0, 2) == 0);
         cfg_rd = ($urandom_range(0, 1) == 0);
         cfg_wr = ($urandom_range(0, 3) == 0);
         cfg_addr = ($urandom_range(0, 3) == 0) ? 8'hF7 : 8'($urandom);
         cfg_wdata = 8'($urandom);
         bank0_rdata = 8'($urandom);
         bank1_rdata = 8'($urandom);
         cyc();
      end
      idle();

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule